// File: doc/BRIEF.md
# Dual-Clock Table Copy Engine

This block moves a complete table of 32-bit words out of a read-only memory that sits in a source clock domain and into a RAM that sits in an unrelated destination clock domain. A source-side sequencer walks the table addresses from the lowest upward. It pushes one word per source clock into an asynchronous FIFO whenever that FIFO has room. A destination-side sequencer pops a word whenever the FIFO reports data. It stores the word at the next RAM address and counts the words it has received.

The FIFO is built inside the block. It has 16 entries, and its read and write pointers cross the clock boundary as Gray code through two-flop synchronizers. Each side has its own active-high synchronous reset. The source side raises a done flag once it has pushed the final address. The destination side raises its own done flag when its counter shows the full table has landed. A registered peek port on the destination clock reads the RAM back, so the copied contents can be inspected.

Top module: `xcopy_top`

## Requirements
- R1: While both resets are held, word_count_o is 0 and wr_done_o and rd_done_o are both 0.
- R2: The source sequencer pushes table addresses in ascending order starting at 0, one per push. Its address holds on every source cycle without a push.
- R3: No word is pushed into the FIFO while its full flag is set. Every word still arrives intact when the destination side is much slower than the source side.
- R4: No word is popped while the FIFO empty flag is set. The destination side stores no extra or repeated words.
- R5: The push of address 0xFF is the last one. On the next source clock edge wr_done_o goes high, and from then on it stays high and no further push occurs.
- R6: After completion, RAM word a equals the table word for a. That word is, from the most significant byte down: the bitwise inverse of a, a XOR 0x5A, a, and the constant 0xC3.
- R7: The word counter and the RAM write address each advance by exactly one on every destination cycle that stores a word. Both hold on every other cycle, so the counter never decreases.
- R8: rd_done_o is high exactly when word_count_o equals 256. The counter never exceeds 256, and once complete it stays at 256.
- R9: peek_data_o shows the RAM word at peek_addr_i one destination clock edge after the address is presented.
- R10: The copy completes correctly for any ratio of the two clock periods, whether the source or the destination clock is faster.
- R11: Asserting both resets in the middle of a copy clears the counter and both done flags. After release, the copy restarts from address 0 and finishes with a correct table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Source-domain clock |
| wrst | input | 1 | Source-domain synchronous reset, active high |
| rclk | input | 1 | Destination-domain clock |
| rrst | input | 1 | Destination-domain synchronous reset, active high |
| wr_done_o | output | 1 | Source side has pushed the whole table |
| rd_done_o | output | 1 | Destination side has stored the whole table |
| word_count_o | output | 9 | Number of words stored into the RAM |
| peek_addr_i | input | 8 | RAM read-back address (destination domain) |
| peek_data_o | output | 32 | RAM read-back data, registered |

## Verification
The hardest situation to reach is a FIFO that sits full for long stretches. In that state the source side must wait on a full flag that clears only several source cycles after each pop, because the pop position has to pass the synchronizer first. The stimulus table reaches it by running the destination clock up to about eight times slower than the source clock. The opposite case runs the destination clock faster, which keeps the FIFO almost always empty and exercises the empty-flag latency. A further directed case resets both domains part-way through a copy and then requires a clean, complete second pass.

// File: rtl/xcopy_pkg.sv
package xcopy_pkg;

  // table geometry
  localparam int TBL_AW  = 8;
  localparam int WORD_W  = 32;
  localparam int FIFO_AW = 4;

  localparam int TBL_WORDS = 1 << TBL_AW;
  localparam int CNT_W     = TBL_AW + 1;

  typedef enum logic {
    WS_PUSH = 1'b0,
    WS_DONE = 1'b1
  } src_state_e;

  typedef enum logic {
    DS_COPY = 1'b0,
    DS_FIN  = 1'b1
  } dst_state_e;

  // contents of the behavioural source table
  function automatic logic [WORD_W-1:0] table_word(input logic [TBL_AW-1:0] a);
    logic [7:0] b;
    b = a;
    return {~b, b ^ 8'h5A, b, 8'hC3};
  endfunction

  function automatic logic [TBL_AW-1:0] next_addr(input logic [TBL_AW-1:0] a);
    return a + 1'b1;
  endfunction

endpackage

// File: rtl/xcopy_sync2.sv
module xcopy_sync2 #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= d;
      stage2 <= stage1;
    end
  end

  assign q = stage2;

endmodule

// File: rtl/xcopy_afifo.sv
module xcopy_afifo #(
  parameter int DW = 32,
  parameter int AW = 4
) (
  input  logic          wclk,
  input  logic          wrst,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  output logic          full,
  input  logic          rclk,
  input  logic          rrst,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic          empty
);

  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] flip_top2(input logic [PW-1:0] g);
    return {~g[PW-1:PW-2], g[PW-3:0]};
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [PW-1:0] wbin, wgray, wbin_nxt, wgray_nxt, wq_rgray;
  logic          wr_fire, full_q, full_nxt;

  assign wr_fire   = push & ~full_q;
  assign wbin_nxt  = wbin + PW'(wr_fire);
  assign wgray_nxt = to_gray(wbin_nxt);
  assign full_nxt  = (wgray_nxt == flip_top2(wq_rgray));

  always_ff @(posedge wclk) begin
    if (wr_fire) mem[wbin[AW-1:0]] <= wdata;
  end

  always_ff @(posedge wclk) begin
    if (wrst) begin
      wbin   <= '0;
      wgray  <= '0;
      full_q <= 1'b0;
    end else begin
      wbin   <= wbin_nxt;
      wgray  <= wgray_nxt;
      full_q <= full_nxt;
    end
  end

  // read domain
  logic [PW-1:0] rbin, rgray, rbin_nxt, rgray_nxt, rq_wgray;
  logic          rd_fire, empty_q, empty_nxt;

  assign rd_fire   = pop & ~empty_q;
  assign rbin_nxt  = rbin + PW'(rd_fire);
  assign rgray_nxt = to_gray(rbin_nxt);
  assign empty_nxt = (rgray_nxt == rq_wgray);

  always_ff @(posedge rclk) begin
    if (rrst) begin
      rbin    <= '0;
      rgray   <= '0;
      empty_q <= 1'b1;
    end else begin
      rbin    <= rbin_nxt;
      rgray   <= rgray_nxt;
      empty_q <= empty_nxt;
    end
  end

  // pointer crossings
  xcopy_sync2 #(.W(PW)) u_w2r (.clk(rclk), .rst(rrst), .d(wgray), .q(rq_wgray));
  xcopy_sync2 #(.W(PW)) u_r2w (.clk(wclk), .rst(wrst), .d(rgray), .q(wq_rgray));

  assign rdata = mem[rbin[AW-1:0]];
  assign full  = full_q;
  assign empty = empty_q;

endmodule

// File: rtl/xcopy_src_ctrl.sv
module xcopy_src_ctrl
  import xcopy_pkg::*;
#(
  parameter int AW = TBL_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_full,
  output logic          push,
  output logic [AW-1:0] rom_addr,
  output logic          done
);

  localparam logic [AW-1:0] LAST = '1;

  src_state_e    state;
  logic [AW-1:0] addr;

  assign push     = (state == WS_PUSH) && !fifo_full;
  assign rom_addr = addr;
  assign done     = (state == WS_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= WS_PUSH;
      addr  <= '0;
    end else if (push) begin
      if (addr == LAST) state <= WS_DONE;
      else              addr  <= addr + 1'b1;
    end
  end

endmodule

// File: rtl/xcopy_dst_ctrl.sv
module xcopy_dst_ctrl
  import xcopy_pkg::*;
#(
  parameter int AW = TBL_AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_empty,
  output logic          pop,
  output logic          ram_we,
  output logic [AW-1:0] ram_addr,
  output logic [AW:0]   count,
  output logic          done
);

  localparam int          TOTAL    = 1 << AW;
  localparam logic [AW:0] PRE_LAST = (AW+1)'(TOTAL - 1);

  dst_state_e    state;
  logic [AW-1:0] waddr;
  logic [AW:0]   cnt;

  assign pop      = (state == DS_COPY) && !fifo_empty;
  assign ram_we   = pop;
  assign ram_addr = waddr;
  assign count    = cnt;
  assign done     = (state == DS_FIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= DS_COPY;
      waddr <= '0;
      cnt   <= '0;
    end else if (pop) begin
      waddr <= waddr + 1'b1;
      cnt   <= cnt + 1'b1;
      if (cnt == PRE_LAST) state <= DS_FIN;
    end
  end

endmodule

// File: rtl/xcopy_mem.sv
module xcopy_rom
  import xcopy_pkg::*;
(
  input  logic [TBL_AW-1:0] addr,
  output logic [WORD_W-1:0] data
);
  assign data = table_word(addr);
endmodule

module xcopy_ram #(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] cells [1 << AW];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end

endmodule

// File: rtl/xcopy_top.sv
module xcopy_top
  import xcopy_pkg::*;
(
  input  logic              wclk,
  input  logic              wrst,
  input  logic              rclk,
  input  logic              rrst,
  output logic              wr_done_o,
  output logic              rd_done_o,
  output logic [TBL_AW:0]   word_count_o,
  input  logic [TBL_AW-1:0] peek_addr_i,
  output logic [WORD_W-1:0] peek_data_o
);

  // named internal events, observed by the bound checker
  logic              wr_push;
  logic              wr_full;
  logic [TBL_AW-1:0] wr_addr;
  logic [WORD_W-1:0] wr_word;
  logic              rd_pop;
  logic              rd_empty;
  logic [WORD_W-1:0] rd_word;
  logic              ram_we;
  logic [TBL_AW-1:0] ram_waddr;

  xcopy_rom u_rom (.addr(wr_addr), .data(wr_word));

  xcopy_src_ctrl #(.AW(TBL_AW)) u_src (
    .clk(wclk), .rst(wrst), .fifo_full(wr_full),
    .push(wr_push), .rom_addr(wr_addr), .done(wr_done_o)
  );

  xcopy_afifo #(.DW(WORD_W), .AW(FIFO_AW)) u_fifo (
    .wclk(wclk), .wrst(wrst), .push(wr_push), .wdata(wr_word), .full(wr_full),
    .rclk(rclk), .rrst(rrst), .pop(rd_pop), .rdata(rd_word), .empty(rd_empty)
  );

  xcopy_dst_ctrl #(.AW(TBL_AW)) u_dst (
    .clk(rclk), .rst(rrst), .fifo_empty(rd_empty),
    .pop(rd_pop), .ram_we(ram_we), .ram_addr(ram_waddr),
    .count(word_count_o), .done(rd_done_o)
  );

  xcopy_ram #(.AW(TBL_AW), .DW(WORD_W)) u_ram (
    .clk(rclk), .we(ram_we), .waddr(ram_waddr), .wdata(rd_word),
    .raddr(peek_addr_i), .rdata(peek_data_o)
  );

endmodule

// File: rtl/xcopy_chk.sv
module xcopy_chk
  import xcopy_pkg::*;
(
  input logic              wclk,
  input logic              wrst,
  input logic              rclk,
  input logic              rrst,
  input logic              wr_push,
  input logic              wr_full,
  input logic [TBL_AW-1:0] wr_addr,
  input logic              wr_done,
  input logic              rd_pop,
  input logic              rd_empty,
  input logic              ram_we,
  input logic [TBL_AW-1:0] ram_waddr,
  input logic [TBL_AW:0]   count,
  input logic              rd_done
);

  localparam logic [TBL_AW-1:0] LAST  = '1;
  localparam logic [TBL_AW:0]   TOTAL = CNT_W'(TBL_WORDS);

  a_r2_addr_ascends: assert property (@(posedge wclk) disable iff (wrst)
    (wr_push && wr_addr != LAST) |=> (wr_addr == $past(wr_addr) + 1'b1));

  a_r2_addr_holds: assert property (@(posedge wclk) disable iff (wrst)
    !wr_push |=> $stable(wr_addr));

  a_r3_no_overflow: assert property (@(posedge wclk) disable iff (wrst)
    wr_full |-> !wr_push);

  a_r4_no_underflow: assert property (@(posedge rclk) disable iff (rrst)
    rd_empty |-> !rd_pop);

  a_r5_done_after_last: assert property (@(posedge wclk) disable iff (wrst)
    (wr_push && wr_addr == LAST) |=> wr_done);

  a_r5_done_quiet: assert property (@(posedge wclk) disable iff (wrst)
    wr_done |=> (wr_done && !wr_push));

  a_r7_count_step: assert property (@(posedge rclk) disable iff (rrst)
    ram_we |=> (count == $past(count) + 1'b1 && ram_waddr == $past(ram_waddr) + 1'b1));

  a_r7_count_hold: assert property (@(posedge rclk) disable iff (rrst)
    !ram_we |=> ($stable(count) && $stable(ram_waddr)));

  a_r8_done_means_total: assert property (@(posedge rclk) disable iff (rrst)
    rd_done |-> (count == TOTAL));

  a_r8_total_means_done: assert property (@(posedge rclk) disable iff (rrst)
    (count == TOTAL) |-> rd_done);

  a_r8_count_bounded: assert property (@(posedge rclk) disable iff (rrst)
    count <= TOTAL);

endmodule

bind xcopy_top xcopy_chk u_chk (
  .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
  .wr_push(wr_push), .wr_full(wr_full), .wr_addr(wr_addr), .wr_done(wr_done_o),
  .rd_pop(rd_pop), .rd_empty(rd_empty), .ram_we(ram_we), .ram_waddr(ram_waddr),
  .count(word_count_o), .rd_done(rd_done_o)
);

// File: tb/test_xcopy_top.sv
module test_xcopy_top;

  localparam int CLK_PERIOD  = 10;
  localparam int NVEC        = 4;
  localparam int TOTAL       = 256;
  localparam int RUN_LIMIT   = 20000;
  localparam int WATCHDOG_NS = 1500000;

  // stimulus vectors: source half period, destination half period
  localparam int W_HALF [NVEC] = '{5, 5, 17, 4};
  localparam int R_HALF [NVEC] = '{5, 18, 5, 31};

  int w_half = CLK_PERIOD / 2;
  int r_half = 7;

  logic        wclk = 1'b0;
  logic        rclk = 1'b0;
  logic        wrst = 1'b1;
  logic        rrst = 1'b1;
  logic [7:0]  peek_addr = 8'h00;
  logic        wr_done, rd_done;
  logic [8:0]  cnt;
  logic [31:0] peek_data;

  int n_chk    = 0;
  int n_fail   = 0;
  int step_err = 0;
  int prev_cnt = 0;

  always #(w_half) wclk = ~wclk;
  always #(r_half) rclk = ~rclk;

  xcopy_top i_xcopy_top (
    .wclk(wclk), .wrst(wrst), .rclk(rclk), .rrst(rrst),
    .wr_done_o(wr_done), .rd_done_o(rd_done), .word_count_o(cnt),
    .peek_addr_i(peek_addr), .peek_data_o(peek_data)
  );

  function automatic logic [31:0] expect_word(input int a);
    logic [7:0] lo;
    lo = 8'(a);
    return {8'(255 - a), lo ^ 8'h5A, lo, 8'hC3};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // R7 counter monitor: step of 0 or 1 per destination cycle, never above total
  always @(negedge rclk) begin
    if (rrst) prev_cnt = 0;
    else begin
      if (int'(cnt) < prev_cnt || int'(cnt) > prev_cnt + 1 || int'(cnt) > TOTAL)
        step_err++;
      prev_cnt = int'(cnt);
    end
  end

  task automatic hold_reset();
    @(negedge wclk);
    wrst = 1'b1;
    rrst = 1'b1;
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
  endtask

  task automatic release_reset();
    @(negedge wclk) wrst = 1'b0;
    @(negedge rclk) rrst = 1'b0;
  endtask

  task automatic run_to_done(input string tag);
    int k = 0;
    while (!rd_done && k < RUN_LIMIT) begin
      @(negedge rclk);
      k++;
    end
    check(rd_done == 1'b1, {"R10 completion ", tag}, 32'(rd_done), 32'd1);
  endtask

  task automatic check_table(input string tag);
    for (int a = 0; a < TOTAL; a++) begin
      @(negedge rclk) peek_addr = 8'(a);
      @(negedge rclk);
      check(peek_data == expect_word(a), {"R6 R9 R2 table word ", tag},
            peek_data, expect_word(a));
    end
  endtask

  task automatic full_pass(input string tag);
    step_err = 0;
    run_to_done(tag);
    // R5: source side finished before the last word could arrive
    check(wr_done == 1'b1, {"R5 source done ", tag}, 32'(wr_done), 32'd1);
    repeat (20) @(negedge rclk);
    // R8 R4: exactly the table size, no extra pops
    check(cnt == 9'(TOTAL), {"R8 R4 final count ", tag}, 32'(cnt), 32'(TOTAL));
    check(rd_done == 1'b1, {"R8 done sticky ", tag}, 32'(rd_done), 32'd1);
    check(wr_done == 1'b1, {"R5 done sticky ", tag}, 32'(wr_done), 32'd1);
    check_table(tag);
    check(step_err == 0, {"R7 count steps ", tag}, 32'(step_err), 32'd0);
  endtask

  initial begin
    #(WATCHDOG_NS);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (4) @(posedge wclk);
    repeat (4) @(posedge rclk);
    @(negedge rclk);
    check(cnt == 9'd0, "R1 count in reset", 32'(cnt), 32'd0);
    check(rd_done == 1'b0, "R1 rd_done in reset", 32'(rd_done), 32'd0);
    @(negedge wclk);
    check(wr_done == 1'b0, "R1 wr_done in reset", 32'(wr_done), 32'd0);

    // R10 R3: table of clock ratios, incl. slow destination keeping the FIFO full
    for (int v = 0; v < NVEC; v++) begin
      w_half = W_HALF[v];
      r_half = R_HALF[v];
      hold_reset();
      release_reset();
      full_pass($sformatf("R3 vec%0d", v));
    end

    // R11: reset in the middle of a copy
    w_half = 5;
    r_half = 9;
    hold_reset();
    release_reset();
    repeat (60) @(negedge rclk);
    check(cnt > 9'd0 && cnt < 9'(TOTAL), "R11 copy in progress", 32'(cnt), 32'd60);
    hold_reset();
    @(negedge rclk);
    check(cnt == 9'd0, "R11 R1 count cleared", 32'(cnt), 32'd0);
    check(rd_done == 1'b0, "R11 rd_done cleared", 32'(rd_done), 32'd0);
    @(negedge wclk);
    check(wr_done == 1'b0, "R11 wr_done cleared", 32'(wr_done), 32'd0);
    release_reset();
    full_pass("R11 restart");

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule